// File: doc/BRIEF.md
# Timed-Access Watchdog Timer

This block is a long-interval supervisory counter. A free-running prescaler produces a slow tick, and the watchdog count advances on each tick. When the count reaches the interval chosen by a two-bit select input, an interrupt flag is raised. If the reset function is armed, a one-cycle reset request follows a fixed number of ticks later, unless software has restarted the count in the meantime. With the reset function disarmed, the interrupt alone turns the block into a very long periodic timer.

Two control bits guard the system against runaway code: the restart bit and the reset-enable bit. Writes to them take effect only during a short window. The window opens when the two-byte key AAh, 55h is written to the key register on back-to-back clock cycles. Outside the window, a write to the control register still updates the unprotected bits, but it cannot restart the count or change the reset enable. A sticky timeout flag records that a watchdog reset took place. It survives the block's own reset request and is cleared only by the power-on reset or by software.

Top module: `wdog_ta`

## Requirements
- R1: The count advances once per 2^PRE_W clocks. The interval select `ivl_sel` = s gives an interval of 2^(BASE_EXP + STEP_EXP*s) ticks, so the defaults give 2^17, 2^20, 2^23 and 2^26 ticks.
- R2: Writing AAh to the key register (address 0) and then 55h on the very next clock cycle opens the window for the three cycles after the 55h write. A gap, a different first byte, or the window running out leaves protected bits locked. The first protected write closes the window.
- R3: The control register at address 1 reads as: bit1 reset enable, bit2 interrupt enable, bit3 interrupt flag, bit4 timeout flag, bit5 priority, all other bits 0. Bit0 (restart) always reads 0. Every other address reads 00h.
- R4: A control write inside the window loads bit1 into reset enable. If bit0 is 1, the same write clears the count, the prescaler and any pending reset. A control write outside the window changes neither and does not restart.
- R5: The interrupt flag is set on the tick where the count reaches the last value of the interval, and counting then wraps to zero. `wd_irq` = flag AND interrupt enable. Writing 0 to bit3 clears the flag and writing 1 leaves it unchanged. A set in the same cycle wins over a clear.
- R6: RST_DELAY ticks after an expiry, if reset enable is 1, `wd_rst` is high for exactly one clock and the count returns to zero. A restart before then cancels the pulse. With reset enable at 0, no pulse is produced.
- R7: The timeout flag (`wd_timeout`, bit4) is set in the same edge that raises `wd_rst`. It stays set through restarts and later pulses. It is cleared only by `rst_n` or by writing 0 to bit4, and writing 1 to bit4 has no effect.
- R8: Interrupt enable (bit2) and priority (bit5) are loaded by any control write, whether the window is open or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 key, 1 control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ivl_sel | input | 2 | Interval select |
| wd_irq | output | 1 | Watchdog interrupt request |
| wd_rst | output | 1 | One-cycle watchdog reset request |
| wd_timeout | output | 1 | Sticky watchdog-reset status |

## Verification
A corrupted tick or count shows up as the interrupt rising on the wrong clock at the very next expiry. The bench therefore checks the exact edge on which `wd_irq` and `wd_rst` change. A wrong unlock state is visible within one or two cycles: read back the reset-enable bit right after a keyed or unkeyed write. A faulty delay counter, or a restart that fails to disarm the pending reset, moves or leaks the `wd_rst` pulse and the timeout flag. A per-clock behavioural model catches this at the first differing cycle.

// File: rtl/wdog_ta_pkg.sv
package wdog_ta_pkg;
   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;

   localparam int B_RESTART = 0;
   localparam int B_RSTEN   = 1;
   localparam int B_IRQEN   = 2;
   localparam int B_IRQF    = 3;
   localparam int B_TOUT    = 4;
   localparam int B_PRIO    = 5;

   typedef struct packed {
      logic prio;
      logic tout;
      logic irqf;
      logic irq_en;
      logic rst_en;
   } ctl_t;
endpackage

// File: rtl/wdog_ta_presc.sv
module wdog_ta_presc #(
   parameter int PRE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (PRE_W == 0) begin : g_direct
         logic unused_pins;
         assign unused_pins = clk ^ rst_n ^ clr;
         assign tick = 1'b1;
      end else begin : g_count
         logic [PRE_W-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pc <= '0;
            else if (clr) pc <= '0;
            else          pc <= pc + PRE_W'(1);
         end
         assign tick = &pc;
      end
   endgenerate
endmodule

// File: rtl/wdog_ta_unlock.sv
module wdog_ta_unlock
   import wdog_ta_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int KEY_ADDR  = 0,
   parameter int CTRL_ADDR = 1,
   parameter int WIN       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic              win_open
);
   localparam int WIN_W = $clog2(WIN + 1);

   logic             first_seen;
   logic [WIN_W-1:0] win;
   logic             wr_key, wr_ctl;

   assign wr_key   = bus_wr && (bus_addr == ADDR_W'(KEY_ADDR));
   assign wr_ctl   = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign win_open = (win != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_seen <= 1'b0;
         win        <= '0;
      end else begin
         first_seen <= wr_key && (bus_wdata == KEY_FIRST);
         if (wr_key && (bus_wdata == KEY_SECOND) && first_seen)
            win <= WIN_W'(WIN);
         else if (wr_ctl && win_open)
            win <= '0;
         else if (win_open)
            win <= win - WIN_W'(1);
      end
   end
endmodule

// File: rtl/wdog_ta_core.sv
module wdog_ta_core #(
   parameter int BASE_EXP  = 17,
   parameter int STEP_EXP  = 3,
   parameter int RST_DELAY = 512
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic [1:0] sel,
   input  logic       rst_en,
   output logic       expire,
   output logic       fire
);
   localparam int CNT_W = BASE_EXP + 3 * STEP_EXP;
   localparam int DLY_W = $clog2(RST_DELAY + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   lim [4];
   logic             armed;
   logic [DLY_W-1:0] dly;
   logic             at_end, dly_done;

   for (genvar g = 0; g < 4; g++) begin : g_lim
      assign lim[g] = (CNT_W+1)'(1) << (BASE_EXP + STEP_EXP * g);
   end

   assign at_end   = (({1'b0, cnt} + (CNT_W+1)'(1)) >= lim[sel]);
   assign dly_done = armed && (dly == DLY_W'(RST_DELAY - 1));
   assign expire   = tick && !restart && at_end;
   assign fire     = tick && !restart && dly_done && rst_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         dly   <= '0;
      end else if (restart) begin
         cnt   <= '0;
         armed <= 1'b0;
         dly   <= '0;
      end else if (tick) begin
         cnt <= at_end ? '0 : cnt + CNT_W'(1);
         if (armed) begin
            if (dly_done) begin
               armed <= 1'b0;
               dly   <= '0;
               if (rst_en) cnt <= '0;
            end else begin
               dly <= dly + DLY_W'(1);
            end
         end else if (at_end) begin
            armed <= 1'b1;
            dly   <= '0;
         end
      end
   end
endmodule

// File: rtl/wdog_ta.sv
module wdog_ta
   import wdog_ta_pkg::*;
#(
   parameter int PRE_W     = 4,
   parameter int BASE_EXP  = 17,
   parameter int STEP_EXP  = 3,
   parameter int RST_DELAY = 512,
   parameter int WIN_CYC   = 3,
   parameter int ADDR_W    = 2,
   parameter int KEY_ADDR  = 0,
   parameter int CTRL_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [1:0]        ivl_sel,
   output logic              wd_irq,
   output logic              wd_rst,
   output logic              wd_timeout
);
   ctl_t ctl_q;
   logic win_open, wr_ctl, prot_wr, restart_ev;
   logic tick, expire, fire;
   logic rst_en_q, irq_en_q;
   logic unused_bits;

   assign unused_bits = ^bus_wdata[7:6];
   assign wr_ctl      = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign prot_wr     = wr_ctl && win_open;
   assign restart_ev  = prot_wr && bus_wdata[B_RESTART];
   assign rst_en_q    = ctl_q.rst_en;
   assign irq_en_q    = ctl_q.irq_en;

   wdog_ta_unlock #(
      .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR), .WIN(WIN_CYC)
   ) u_unlock (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .win_open(win_open)
   );

   wdog_ta_presc #(.PRE_W(PRE_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(restart_ev), .tick(tick)
   );

   wdog_ta_core #(
      .BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .RST_DELAY(RST_DELAY)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart_ev), .sel(ivl_sel),
      .rst_en(ctl_q.rst_en), .expire(expire), .fire(fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         wd_rst <= 1'b0;
      end else begin
         wd_rst <= fire;
         if (wr_ctl) begin
            ctl_q.irq_en <= bus_wdata[B_IRQEN];
            ctl_q.prio   <= bus_wdata[B_PRIO];
            if (!bus_wdata[B_IRQF]) ctl_q.irqf <= 1'b0;
            if (!bus_wdata[B_TOUT]) ctl_q.tout <= 1'b0;
         end
         if (prot_wr) ctl_q.rst_en <= bus_wdata[B_RSTEN];
         if (expire)  ctl_q.irqf   <= 1'b1;
         if (fire)    ctl_q.tout   <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
         bus_rdata[B_RSTEN] = ctl_q.rst_en;
         bus_rdata[B_IRQEN] = ctl_q.irq_en;
         bus_rdata[B_IRQF]  = ctl_q.irqf;
         bus_rdata[B_TOUT]  = ctl_q.tout;
         bus_rdata[B_PRIO]  = ctl_q.prio;
      end
   end

   assign wd_irq     = ctl_q.irqf && ctl_q.irq_en;
   assign wd_timeout = ctl_q.tout;
endmodule

// File: rtl/wdog_ta_chk.sv
module wdog_ta_chk #(
   parameter int ADDR_W    = 2,
   parameter int CTRL_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              win_open,
   input logic              rst_en,
   input logic              irq_en,
   input logic              restart,
   input logic              wd_irq,
   input logic              wd_rst,
   input logic              wd_timeout
);
   logic ctl_wr;
   logic unused_data;
   assign ctl_wr      = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign unused_data = ^{bus_wdata[7:5], bus_wdata[3:0]};

   assert_one_cycle_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |=> !wd_rst);

   assert_restart_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !wd_rst);

   assert_timeout_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |-> wd_timeout);

   assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_timeout && !(ctl_wr && !bus_wdata[4])) |=> wd_timeout);

   assert_locked_rsten_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !win_open) |=> $stable(rst_en));

   assert_window_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && win_open) |=> !win_open);

   assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_irq |-> irq_en);
endmodule

bind wdog_ta wdog_ta_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .win_open(win_open), .rst_en(rst_en_q),
   .irq_en(irq_en_q), .restart(restart_ev), .wd_irq(wd_irq),
   .wd_rst(wd_rst), .wd_timeout(wd_timeout)
);

// File: tb/wdog_ta_tb.sv
module wdog_ta_tb;
   localparam int PRE_W = 2;
   localparam int BASE  = 3;
   localparam int STEP  = 1;
   localparam int DLY   = 5;
   localparam int WIN   = 3;

   logic       clk = 1'b0;
   logic       rst_n, bus_wr;
   logic [1:0] bus_addr, ivl_sel;
   logic [7:0] bus_wdata, bus_rdata;
   logic       wd_irq, wd_rst, wd_timeout;

   always #5 clk = ~clk;

   wdog_ta #(
      .PRE_W(PRE_W), .BASE_EXP(BASE), .STEP_EXP(STEP), .RST_DELAY(DLY),
      .WIN_CYC(WIN), .ADDR_W(2), .KEY_ADDR(0), .CTRL_ADDR(1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ivl_sel(ivl_sel),
      .wd_irq(wd_irq), .wd_rst(wd_rst), .wd_timeout(wd_timeout)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   // behavioural reference, advanced once per clock
   int m_pc, m_cnt, m_dly, m_win;
   bit m_armed, m_aa, m_rsten, m_irqen, m_prio, m_irqf, m_tst, m_rst;

   always @(posedge clk) begin
      logic [7:0] erd;
      bit wa, wc, prot, rs, tk, ex, rv, narm;
      int per, ncnt, ndly;
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual %0d expected <150000", cyc);
         summary();
         $finish;
      end
      if (!rst_n) begin
         m_pc = 0; m_cnt = 0; m_dly = 0; m_win = 0; m_armed = 0; m_aa = 0;
         m_rsten = 0; m_irqen = 0; m_prio = 0; m_irqf = 0; m_tst = 0; m_rst = 0;
      end else begin
         erd = (bus_addr == 2'd1) ? {2'b00, m_prio, m_tst, m_irqf, m_irqen, m_rsten, 1'b0} : 8'h00;
         chk("R3 readback", int'(bus_rdata), int'(erd));
         chk("R5 wd_irq", int'(wd_irq), int'(m_irqf & m_irqen));
         chk("R6 wd_rst", int'(wd_rst), int'(m_rst));
         chk("R7 wd_timeout", int'(wd_timeout), int'(m_tst));

         wa   = bus_wr && bus_addr == 2'd0;
         wc   = bus_wr && bus_addr == 2'd1;
         prot = wc && (m_win > 0);
         rs   = prot && bus_wdata[0];
         tk   = (m_pc == (1 << PRE_W) - 1);
         per  = 1 << (BASE + STEP * int'(ivl_sel));
         ex = 0; rv = 0;
         if (rs) begin
            m_pc = 0; m_cnt = 0; m_armed = 0; m_dly = 0;
         end else begin
            if (tk) begin
               ex   = (m_cnt + 1 >= per);
               ncnt = ex ? 0 : m_cnt + 1;
               narm = m_armed;
               ndly = m_dly;
               if (m_armed) begin
                  if (m_dly == DLY - 1) begin
                     narm = 0; ndly = 0; rv = m_rsten;
                     if (m_rsten) ncnt = 0;
                  end else ndly = m_dly + 1;
               end else if (ex) begin
                  narm = 1; ndly = 0;
               end
               m_cnt = ncnt; m_armed = narm; m_dly = ndly;
            end
            m_pc = (m_pc + 1) % (1 << PRE_W);
         end
         if (wc) begin
            m_irqen = bus_wdata[2];
            m_prio  = bus_wdata[5];
            if (!bus_wdata[3]) m_irqf = 0;
            if (!bus_wdata[4]) m_tst = 0;
         end
         if (prot) m_rsten = bus_wdata[1];
         if (ex) m_irqf = 1;
         if (rv) m_tst = 1;
         m_rst = rv;
         if (wa && bus_wdata == 8'h55 && m_aa) m_win = WIN;
         else if (prot) m_win = 0;
         else if (m_win > 0) m_win--;
         m_aa = wa && bus_wdata == 8'hAA;
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock();
      bus_write(2'd0, 8'hAA);
      bus_write(2'd0, 8'h55);
   endtask

   task automatic keyed_ctl(input logic [7:0] d);
      unlock();
      bus_write(2'd1, d);
   endtask

   task automatic rd_ctl(output logic [7:0] v);
      bus_addr = 2'd1;
      #1 v = bus_rdata;
   endtask

   task automatic watch_no_rst(input int n, output bit seen);
      seen = 0;
      repeat (n) begin
         @(negedge clk);
         if (wd_rst) seen = 1;
      end
   endtask

   initial begin
      logic [7:0] v;
      bit seen;
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00; ivl_sel = 2'd3;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // reset state
      rd_ctl(v);
      chk("R3 reset control value", int'(v), 'h00);
      chk("R5 reset irq", int'(wd_irq), 0);
      chk("R7 reset timeout", int'(wd_timeout), 0);

      // plain write: protected bits locked, plain bits land
      bus_write(2'd1, 8'h27);
      rd_ctl(v);
      chk("R4 R8 unkeyed write readback", int'(v), 'h24);

      // window expired after three idle cycles
      unlock(); wait_n(3); bus_write(2'd1, 8'h02);
      rd_ctl(v);
      chk("R2 late write rejected", int'(v), 'h00);
      // last open cycle accepted
      unlock(); wait_n(2); bus_write(2'd1, 8'h06);
      rd_ctl(v);
      chk("R2 R4 in-window write", int'(v), 'h06);
      // one protected write closes the window
      bus_write(2'd1, 8'h04);
      rd_ctl(v);
      chk("R2 window closed after one write", int'(v), 'h06);
      // gap between key bytes
      bus_write(2'd0, 8'hAA); wait_n(1); bus_write(2'd0, 8'h55); bus_write(2'd1, 8'h04);
      rd_ctl(v);
      chk("R2 gapped key rejected", int'(v), 'h06);
      // wrong first byte
      bus_write(2'd0, 8'hA5); bus_write(2'd0, 8'h55); bus_write(2'd1, 8'h04);
      rd_ctl(v);
      chk("R2 wrong key rejected", int'(v), 'h06);

      // expiry and reset timing, shortest interval
      ivl_sel = 2'd0;
      keyed_ctl(8'h07);
      wait_n(20);
      bus_write(2'd1, 8'h05);              // unkeyed restart must be ignored
      wait_n(10);
      chk("R1 R4 irq low before interval end", int'(wd_irq), 0);
      wait_n(1);
      chk("R1 R5 irq at interval end", int'(wd_irq), 1);
      wait_n(19);
      chk("R6 no pulse before delay", int'(wd_rst), 0);
      wait_n(1);
      chk("R6 pulse after delay", int'(wd_rst), 1);
      chk("R7 timeout with pulse", int'(wd_timeout), 1);
      wait_n(1);
      chk("R6 pulse one cycle", int'(wd_rst), 0);

      // timeout clearing
      bus_write(2'd1, 8'h1C);
      chk("R7 write 1 keeps timeout", int'(wd_timeout), 1);
      bus_write(2'd1, 8'h0C);
      chk("R7 write 0 clears timeout", int'(wd_timeout), 0);

      // reset disabled: long timer only
      keyed_ctl(8'h05);
      rd_ctl(v);
      chk("R4 reset enable cleared", int'(v), 'h04);
      watch_no_rst(60, seen);
      chk("R6 no pulse when disabled", int'(seen), 0);
      chk("R5 irq without reset", int'(wd_irq), 1);
      bus_write(2'd1, 8'h04);
      chk("R5 flag cleared by write 0", int'(wd_irq), 0);
      wait_n(3);
      chk("R5 periodic re-expiry", int'(wd_irq), 1);

      // restart between expiry and pulse cancels it
      keyed_ctl(8'h07);
      watch_no_rst(40, seen);
      keyed_ctl(8'h07);
      begin
         bit seen2;
         watch_no_rst(45, seen2);
         chk("R6 restart cancels pending pulse", int'(seen | seen2), 0);
      end

      // longer interval
      ivl_sel = 2'd2;
      keyed_ctl(8'h05);
      wait_n(127);
      chk("R1 sel2 irq low", int'(wd_irq), 0);
      wait_n(1);
      chk("R1 sel2 irq at 32 ticks", int'(wd_irq), 1);

      // timeout survives restart, cleared by power-on reset
      ivl_sel = 2'd0;
      keyed_ctl(8'h07);
      wait_n(53);
      chk("R7 timeout after second pulse", int'(wd_timeout), 1);
      keyed_ctl(8'h17);
      chk("R7 timeout survives restart", int'(wd_timeout), 1);
      bus_addr = 2'd2;
      #1 chk("R3 other address reads zero", int'(bus_rdata), 'h00);
      rd_ctl(v);
      chk("R3 restart bit reads zero", int'(v[0]), 0);
      @(negedge clk);
      rst_n = 1'b0;
      #1 chk("R7 cleared by rst_n", int'(wd_timeout), 0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_n(4);
      summary();
      $finish;
   end
endmodule